// File: doc/BRIEF.md
# Automatic Modem-Line Flow Controller

This block owns the handshake pins of one serial channel. On the receive side it drives the active-low request-to-send and data-terminal-ready outputs from the receive FIFO fill. Each output has its own pair of hysteresis thresholds, so the far end is throttled before the FIFO overflows and is released only after the FIFO has drained well below the high mark. On the transmit side it gates the start of new data characters on the active-low clear-to-send and data-set-ready inputs. It never cuts off a character that has already started. In-band flow-control characters are always allowed through.

The same pins can take on other roles. The data-terminal-ready output can instead steer the direction of a half-duplex RS485 transceiver from the transmitter-empty status. It can also carry the 1x or Nx transmit clock out for isochronous links. The data-set-ready input can become an external receive clock, and the ring-indicator input can become an external transmit clock that the receiver also uses. When a pin is repurposed, its flow-control use stops and its status bit reads as inactive.

All asynchronous modem inputs pass through a two-flop synchronizer before they are used for gating or status. The shift registers, FIFOs and baud generator sit outside this block. The block sees them only through the level, busy, empty and request signals.

Top module: `mfc_modem_ctrl`

## Requirements
- R1: With `auto_rts` high, `rts_n` goes to 1 on the clock edge after `rx_level >= rts_thr_hi`, and goes to 0 on the clock edge after `rx_level <= rts_thr_lo` (with the level below the high mark). Between the two marks it keeps its value.
- R2: With `auto_dtr` high and `dir_mode` = 00, `dtr_n` follows the rule of R1 using `dtr_thr_hi` and `dtr_thr_lo`. That state is independent of the request-to-send state.
- R3: With `auto_cts` high, once `cts_n_pin` has been 1 for three consecutive clock edges, `tx_allow` is 0 and `start_data` stays 0. A character in progress (`tx_busy` = 1) is never affected, and `start_data` is 0 whenever `tx_busy` is 1. Reasserting the pin reopens `tx_allow` on the third edge.
- R4: With `auto_dsr` high and `dsr_n_pin` not repurposed, the data-set-ready pin gates the transmitter exactly as in R3.
- R5: `start_flow` equals 1 whenever `flow_req` is 1 and `tx_busy` is 0, regardless of both gates. When `flow_req` and `data_req` meet in the same idle cycle, only `start_flow` is 1.
- R6: `dir_mode` selects the RS485 direction drive of `dtr_n`, one edge after `tx_empty` changes. 01 or 11 gives `dtr_n` = `tx_empty` (low while anything is still in the shift path, including the stop bit). 10 gives the inverse. 00 gives the normal data-terminal-ready function.
- R7: When `rx_clk_src` = 01, `ext_rx_clk` follows `dsr_n_pin`, `dsr_stat` reads 0, and the pin no longer gates the transmitter. For any other code `ext_rx_clk` is 0.
- R8: When `tx_clk_ext_sel` is 1, `ext_tx_clk` follows `ri_n_pin` and `ri_stat` reads 0. Otherwise `ext_tx_clk` is 0.
- R9: `dtr_clk_route` = 01 puts `tx_clk_1x` on `dtr_n`, and 10 puts `tx_clk_nx` on it. Both override R2 and R6. The codes 00 and 11 leave the registered drive on the pin.
- R10: Each status output (`cts_stat`, `dsr_stat`, `dcd_stat`, `ri_stat`, 1 = asserted) shows a pin change on the second clock edge after it, not the first.
- R11: In reset `rts_n` and `dtr_n` are 1 and `tx_allow` is 0. With automatic control off, `rts_n` = ~`rts_manual` and `dtr_n` = ~`dtr_manual` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rts_thr_hi | input | LVL_W | Request-to-send stop mark |
| rts_thr_lo | input | LVL_W | Request-to-send resume mark |
| dtr_thr_hi | input | LVL_W | Data-terminal-ready stop mark |
| dtr_thr_lo | input | LVL_W | Data-terminal-ready resume mark |
| auto_rts | input | 1 | Enable automatic request-to-send |
| auto_dtr | input | 1 | Enable automatic data-terminal-ready |
| auto_cts | input | 1 | Enable clear-to-send transmit gate |
| auto_dsr | input | 1 | Enable data-set-ready transmit gate |
| rts_manual | input | 1 | Software request-to-send value (1 = assert) |
| dtr_manual | input | 1 | Software data-terminal-ready value (1 = assert) |
| dir_mode | input | 2 | RS485 direction mode |
| rx_clk_src | input | 2 | Receive clock source, 01 = data-set-ready pin |
| dtr_clk_route | input | 2 | Transmit clock onto data-terminal-ready pin |
| tx_clk_ext_sel | input | 1 | Ring-indicator pin used as transmit clock |
| tx_busy | input | 1 | A character is being shifted out |
| tx_empty | input | 1 | Holding and shift registers both empty |
| data_req | input | 1 | Core has a data character to start |
| flow_req | input | 1 | Core has an in-band flow character to start |
| tx_clk_1x | input | 1 | 1x transmit clock from baud generator |
| tx_clk_nx | input | 1 | Nx transmit clock from baud generator |
| cts_n_pin | input | 1 | Clear-to-send pin, active low |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low |
| ri_n_pin | input | 1 | Ring-indicator pin, active low |
| rts_n | output | 1 | Request-to-send pin drive |
| dtr_n | output | 1 | Data-terminal-ready pin drive |
| tx_allow | output | 1 | Transmit gate open |
| start_data | output | 1 | Grant: start a data character now |
| start_flow | output | 1 | Grant: start a flow character now |
| cts_stat | output | 1 | Clear-to-send status |
| dsr_stat | output | 1 | Data-set-ready status |
| dcd_stat | output | 1 | Carrier-detect status |
| ri_stat | output | 1 | Ring-indicator status |
| ext_rx_clk | output | 1 | External receive clock |
| ext_tx_clk | output | 1 | External transmit clock, also for receiver |

## Verification
Two things can meet in one idle cycle: the transmit gate closing on a deasserted clear-to-send, and a pending in-band flow character. The bench closes the gate while a character is in flight with both `data_req` and `flow_req` held. It then drops `tx_busy` and expects only `start_flow` to rise. A second meeting point is the data-terminal-ready pin, where the clock route, the RS485 direction and the threshold drive all compete. The bench layers them and checks that the pin shows the highest-priority source. The threshold logic is also driven with random fill levels biased toward the marks, and is compared each cycle against a model in the bench.

// File: rtl/mfc_pkg.sv
// Shared encodings for the modem-line flow controller.
package mfc_pkg;
    typedef enum logic [1:0] {
        DIR_OFF           = 2'b00,
        DIR_LOW_WHILE_TX  = 2'b01,
        DIR_HIGH_WHILE_TX = 2'b10,
        DIR_LOW_ALT       = 2'b11
    } dir_mode_e;

    typedef enum logic [1:0] {
        ROUTE_NONE     = 2'b00,
        ROUTE_1X       = 2'b01,
        ROUTE_NX       = 2'b10,
        ROUTE_NONE_ALT = 2'b11
    } clk_route_e;

    localparam logic [1:0] RXSRC_DSR_PIN = 2'b01;
    localparam int         NUM_HYST      = 2;
    localparam int         HYST_RTS      = 0;
    localparam int         HYST_DTR      = 1;
endpackage

// File: rtl/mfc_sync.sv
// Multi-stage synchronizer for asynchronous modem inputs.
// Assumes STAGES >= 2; resets to RST_VAL (idle pin levels).
module mfc_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw pins through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mfc_hyst.sv
// Hysteresis comparator on a FIFO fill level.
// ready_d is the next "receiver ready" state: cleared at or above thr_hi,
// set at or below thr_lo, held in between. Disabled means ready.
module mfc_hyst #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    output logic             ready_d
);
    logic ready_q;

    // Next state: high mark wins over low mark.
    always_comb begin
        if (!en)                  ready_d = 1'b1;
        else if (level >= thr_hi) ready_d = 1'b0;
        else if (level <= thr_lo) ready_d = 1'b1;
        else                      ready_d = ready_q;
    end

    // Hold the state between the marks.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b1;
        else        ready_q <= ready_d;
    end
endmodule

// File: rtl/mfc_txgate.sv
// Transmit gate. tx_allow is a registered view of the synchronized
// handshake inputs. Starts are granted only while the shift path is idle,
// so a character already in flight always completes. Flow characters
// bypass the gate and win over data in the same cycle.
module mfc_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_on,
    input  logic dsr_on,
    input  logic dsr_is_clk,
    input  logic cts_asserted,
    input  logic dsr_asserted,
    input  logic tx_busy,
    input  logic data_req,
    input  logic flow_req,
    output logic tx_allow,
    output logic start_data,
    output logic start_flow
);
    logic open_d;

    // Gate condition from both enabled handshake lines.
    always_comb begin
        open_d = (!cts_on || cts_asserted) &&
                 (!dsr_on || dsr_is_clk || dsr_asserted);
    end

    // Register the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_allow <= 1'b0;
        else        tx_allow <= open_d;
    end

    // Start grants at character boundaries only.
    always_comb begin
        start_flow = !tx_busy && flow_req;
        start_data = !tx_busy && !flow_req && data_req && tx_allow;
    end
endmodule

// File: rtl/mfc_modem_ctrl.sv
// Automatic modem-line flow controller for one serial channel.
// Drives active-low request/terminal-ready lines from FIFO fill with
// hysteresis, gates new transmit characters on clear-to-send and
// data-set-ready, and repurposes pins for RS485 direction and clocks.
// Assumes pins are asynchronous; clocks passed through are not synchronized.
module mfc_modem_ctrl
    import mfc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rts_thr_hi,
    input  logic [LVL_W-1:0] rts_thr_lo,
    input  logic [LVL_W-1:0] dtr_thr_hi,
    input  logic [LVL_W-1:0] dtr_thr_lo,
    input  logic             auto_rts,
    input  logic             auto_dtr,
    input  logic             auto_cts,
    input  logic             auto_dsr,
    input  logic             rts_manual,
    input  logic             dtr_manual,
    input  logic [1:0]       dir_mode,
    input  logic [1:0]       rx_clk_src,
    input  logic [1:0]       dtr_clk_route,
    input  logic             tx_clk_ext_sel,
    input  logic             tx_busy,
    input  logic             tx_empty,
    input  logic             data_req,
    input  logic             flow_req,
    input  logic             tx_clk_1x,
    input  logic             tx_clk_nx,
    input  logic             cts_n_pin,
    input  logic             dsr_n_pin,
    input  logic             dcd_n_pin,
    input  logic             ri_n_pin,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_allow,
    output logic             start_data,
    output logic             start_flow,
    output logic             cts_stat,
    output logic             dsr_stat,
    output logic             dcd_stat,
    output logic             ri_stat,
    output logic             ext_rx_clk,
    output logic             ext_tx_clk
);
    localparam int PIN_W = 4;

    dir_mode_e  dmode;
    clk_route_e route;
    logic       dsr_is_clk;
    logic       dir_active;
    logic       dtr_q;
    logic       rts_q;
    logic [PIN_W-1:0] pins_s;
    logic [NUM_HYST-1:0] hyst_en;
    logic [NUM_HYST-1:0] ready_d;
    logic [LVL_W-1:0]    thr_hi [NUM_HYST];
    logic [LVL_W-1:0]    thr_lo [NUM_HYST];

    // Decode mode fields.
    always_comb begin
        dmode      = dir_mode_e'(dir_mode);
        route      = clk_route_e'(dtr_clk_route);
        dsr_is_clk = (rx_clk_src == RXSRC_DSR_PIN);
        dir_active = (dmode != DIR_OFF);
    end

    // Synchronize modem inputs: {ri, dcd, dsr, cts}.
    mfc_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ri_n_pin, dcd_n_pin, dsr_n_pin, cts_n_pin}),
        .q    (pins_s)
    );

    // Threshold pairs per automatic output.
    always_comb begin
        hyst_en[HYST_RTS] = auto_rts;
        hyst_en[HYST_DTR] = auto_dtr && !dir_active;
        thr_hi[HYST_RTS]  = rts_thr_hi;
        thr_lo[HYST_RTS]  = rts_thr_lo;
        thr_hi[HYST_DTR]  = dtr_thr_hi;
        thr_lo[HYST_DTR]  = dtr_thr_lo;
    end

    for (genvar g = 0; g < NUM_HYST; g++) begin : g_hyst
        mfc_hyst #(.LVL_W(LVL_W)) u_hyst (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (hyst_en[g]),
            .level  (rx_level),
            .thr_hi (thr_hi[g]),
            .thr_lo (thr_lo[g]),
            .ready_d(ready_d[g])
        );
    end

    // Register the request-to-send pin drive.
    always_ff @(posedge clk) begin
        if (!rst_n)        rts_q <= 1'b1;
        else if (auto_rts) rts_q <= !ready_d[HYST_RTS];
        else               rts_q <= !rts_manual;
    end

    // Register the terminal-ready drive: RS485 direction beats thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtr_q <= 1'b1;
        end else begin
            unique case (dmode)
                DIR_HIGH_WHILE_TX: dtr_q <= !tx_empty;
                DIR_LOW_WHILE_TX,
                DIR_LOW_ALT:       dtr_q <= tx_empty;
                default:           dtr_q <= auto_dtr ? !ready_d[HYST_DTR] : !dtr_manual;
            endcase
        end
    end

    // Clock routing overrides the registered drive on the pin.
    always_comb begin
        unique case (route)
            ROUTE_1X: dtr_n = tx_clk_1x;
            ROUTE_NX: dtr_n = tx_clk_nx;
            default:  dtr_n = dtr_q;
        endcase
    end

    assign rts_n = rts_q;

    mfc_txgate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_on      (auto_cts),
        .dsr_on      (auto_dsr),
        .dsr_is_clk  (dsr_is_clk),
        .cts_asserted(!pins_s[0]),
        .dsr_asserted(!pins_s[1]),
        .tx_busy     (tx_busy),
        .data_req    (data_req),
        .flow_req    (flow_req),
        .tx_allow    (tx_allow),
        .start_data  (start_data),
        .start_flow  (start_flow)
    );

    // Status readback, masked when a pin carries a clock.
    always_comb begin
        cts_stat   = !pins_s[0];
        dsr_stat   = !pins_s[1] && !dsr_is_clk;
        dcd_stat   = !pins_s[2];
        ri_stat    = !pins_s[3] && !tx_clk_ext_sel;
        ext_rx_clk = dsr_is_clk && dsr_n_pin;
        ext_tx_clk = tx_clk_ext_sel && ri_n_pin;
    end
endmodule

// File: rtl/mfc_modem_ctrl_chk.sv
// Property checker for mfc_modem_ctrl, attached by bind.
// Counters measure how long a handshake pin has been deasserted.
module mfc_modem_ctrl_chk #(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] rts_thr_hi,
    input logic [LVL_W-1:0] rts_thr_lo,
    input logic [LVL_W-1:0] dtr_thr_hi,
    input logic             auto_rts,
    input logic             auto_dtr,
    input logic             auto_cts,
    input logic             auto_dsr,
    input logic [1:0]       dir_mode,
    input logic [1:0]       rx_clk_src,
    input logic [1:0]       dtr_clk_route,
    input logic             tx_clk_ext_sel,
    input logic             tx_busy,
    input logic             tx_empty,
    input logic             cts_n_pin,
    input logic             dsr_n_pin,
    input logic             rts_n,
    input logic             dtr_n,
    input logic             tx_allow,
    input logic             start_data,
    input logic             start_flow,
    input logic             dsr_stat,
    input logic             ri_stat
);
    logic [1:0] cts_hi_cnt;
    logic [1:0] dsr_hi_cnt;

    // Count consecutive edges with the gating pin deasserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_hi_cnt <= '0;
            dsr_hi_cnt <= '0;
        end else begin
            if (auto_cts && cts_n_pin) cts_hi_cnt <= (cts_hi_cnt == 2'd3) ? 2'd3 : cts_hi_cnt + 2'd1;
            else                       cts_hi_cnt <= '0;
            if (auto_dsr && dsr_n_pin && rx_clk_src != 2'b01)
                dsr_hi_cnt <= (dsr_hi_cnt == 2'd3) ? 2'd3 : dsr_hi_cnt + 2'd1;
            else
                dsr_hi_cnt <= '0;
        end
    end

    AST_RTS_STOP_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && rx_level >= rts_thr_hi) |=> rts_n); // R1
    AST_RTS_GO_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && rx_level <= rts_thr_lo && rx_level < rts_thr_hi) |=> !rts_n); // R1
    AST_DTR_STOP_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dtr && dir_mode == 2'b00 && rx_level >= dtr_thr_hi) |=> (dtr_clk_route == 2'b01 || dtr_clk_route == 2'b10 || dtr_n)); // R2
    AST_CTS_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_hi_cnt == 2'd3) |-> (!tx_allow && !start_data)); // R3
    AST_BUSY_NO_DATA_START: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !start_data); // R3
    AST_DSR_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (dsr_hi_cnt == 2'd3) |-> (!tx_allow && !start_data)); // R4
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_data, start_flow})); // R5
    AST_DIR_LOW_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode == 2'b01 && !tx_empty) |=> (dtr_clk_route == 2'b01 || dtr_clk_route == 2'b10 || !dtr_n)); // R6
    AST_DSR_STAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clk_src == 2'b01) |-> !dsr_stat); // R7
    AST_RI_STAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_ext_sel |-> !ri_stat); // R8
endmodule

bind mfc_modem_ctrl mfc_modem_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_level      (rx_level),
    .rts_thr_hi    (rts_thr_hi),
    .rts_thr_lo    (rts_thr_lo),
    .dtr_thr_hi    (dtr_thr_hi),
    .auto_rts      (auto_rts),
    .auto_dtr      (auto_dtr),
    .auto_cts      (auto_cts),
    .auto_dsr      (auto_dsr),
    .dir_mode      (dir_mode),
    .rx_clk_src    (rx_clk_src),
    .dtr_clk_route (dtr_clk_route),
    .tx_clk_ext_sel(tx_clk_ext_sel),
    .tx_busy       (tx_busy),
    .tx_empty      (tx_empty),
    .cts_n_pin     (cts_n_pin),
    .dsr_n_pin     (dsr_n_pin),
    .rts_n         (rts_n),
    .dtr_n         (dtr_n),
    .tx_allow      (tx_allow),
    .start_data    (start_data),
    .start_flow    (start_flow),
    .dsr_stat      (dsr_stat),
    .ri_stat       (ri_stat)
);

// File: tb/mfc_modem_ctrl_test.sv
module mfc_modem_ctrl_test;
    localparam int DEPTH = 64;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int WATCHDOG_CYCLES = 50000;

    logic clk = 1'b0;
    logic rst_n;
    logic [LW-1:0] rx_level, rts_thr_hi, rts_thr_lo, dtr_thr_hi, dtr_thr_lo;
    logic auto_rts, auto_dtr, auto_cts, auto_dsr, rts_manual, dtr_manual;
    logic [1:0] dir_mode, rx_clk_src, dtr_clk_route;
    logic tx_clk_ext_sel, tx_busy, tx_empty, data_req, flow_req, tx_clk_1x, tx_clk_nx;
    logic cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin;
    logic rts_n, dtr_n, tx_allow, start_data, start_flow;
    logic cts_stat, dsr_stat, dcd_stat, ri_stat, ext_rx_clk, ext_tx_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mfc_modem_ctrl #(.FIFO_DEPTH(DEPTH)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Hysteresis model: returns next "ready" state.
    function automatic logic hyst_next(input logic en, input logic [LW-1:0] lvl,
                                       input logic [LW-1:0] hi, input logic [LW-1:0] lo,
                                       input logic st);
        if (!en)        return 1'b1;
        if (lvl >= hi)  return 1'b0;
        if (lvl <= lo)  return 1'b1;
        return st;
    endfunction

    function automatic logic [LW-1:0] pick_level(input logic [LW-1:0] hi, input logic [LW-1:0] lo);
        int unsigned r;
        r = $urandom % 8;
        if (r == 0) return hi;
        if (r == 1) return lo;
        if (r == 2) return hi - 1'b1;
        if (r == 3) return lo + 1'b1;
        return LW'($urandom % (DEPTH + 1));
    endfunction

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic m_rts, m_dtr, e_rts, e_dtr;
        void'($urandom(32'h5EED));
        rst_n = 1'b0;
        rx_level = '0; rts_thr_hi = '0; rts_thr_lo = '0; dtr_thr_hi = '0; dtr_thr_lo = '0;
        auto_rts = 0; auto_dtr = 0; auto_cts = 0; auto_dsr = 0; rts_manual = 0; dtr_manual = 0;
        dir_mode = 2'b00; rx_clk_src = 2'b00; dtr_clk_route = 2'b00; tx_clk_ext_sel = 0;
        tx_busy = 0; tx_empty = 1; data_req = 0; flow_req = 0; tx_clk_1x = 0; tx_clk_nx = 0;
        cts_n_pin = 1; dsr_n_pin = 1; dcd_n_pin = 1; ri_n_pin = 1;
        tick(3);
        check("R11 reset rts_n", rts_n, 1);
        check("R11 reset dtr_n", dtr_n, 1);
        check("R11 reset tx_allow", tx_allow, 0);
        rst_n = 1'b1;

        // R11 manual drive
        rts_manual = 1; dtr_manual = 1; tick(1);
        check("R11 manual rts", rts_n, 0);
        check("R11 manual dtr", dtr_n, 0);
        rts_manual = 0; dtr_manual = 0; tick(1);
        check("R11 manual rts off", rts_n, 1);
        tick(2);

        // R10 two-edge synchronizer latency
        cts_n_pin = 0; tick(1);
        check("R10 cts after one edge", cts_stat, 0);
        tick(1);
        check("R10 cts after two edges", cts_stat, 1);
        dcd_n_pin = 0; tick(2);
        check("R10 dcd status", dcd_stat, 1);

        // R1 / R2 directed boundaries
        auto_rts = 1; rts_thr_hi = 48; rts_thr_lo = 16;
        rx_level = 20; tick(1); check("R1 start asserted", rts_n, 0);
        rx_level = 48; tick(1); check("R1 at high mark", rts_n, 1);
        rx_level = 47; tick(1); check("R1 in band held off", rts_n, 1);
        rx_level = 17; tick(1); check("R1 above low held off", rts_n, 1);
        rx_level = 16; tick(1); check("R1 at low mark", rts_n, 0);
        rx_level = 30; tick(1); check("R1 in band held on", rts_n, 0);
        auto_dtr = 1; dtr_thr_hi = 40; dtr_thr_lo = 10;
        rx_level = 40; tick(1);
        check("R2 dtr at own high mark", dtr_n, 1);
        check("R2 rts independent", rts_n, 0);
        rx_level = 10; tick(1); check("R2 dtr at own low mark", dtr_n, 0);

        // R1 / R2 random levels against model
        m_rts = 1'b1; m_dtr = 1'b0;
        m_dtr = 1'b1;
        for (int blk = 0; blk < 4; blk++) begin
            rts_thr_lo = LW'($urandom % 40);
            rts_thr_hi = rts_thr_lo + LW'(1 + $urandom % (DEPTH - 40));
            dtr_thr_lo = LW'($urandom % 40);
            dtr_thr_hi = dtr_thr_lo + LW'(1 + $urandom % (DEPTH - 40));
            for (int i = 0; i < 100; i++) begin
                rx_level = pick_level(((i % 2) == 0) ? rts_thr_hi : dtr_thr_hi,
                                      ((i % 2) == 0) ? rts_thr_lo : dtr_thr_lo);
                m_rts = hyst_next(1'b1, rx_level, rts_thr_hi, rts_thr_lo, m_rts);
                m_dtr = hyst_next(1'b1, rx_level, dtr_thr_hi, dtr_thr_lo, m_dtr);
                e_rts = !m_rts;
                e_dtr = !m_dtr;
                tick(1);
                check("R1 random rts", rts_n, e_rts);
                check("R2 random dtr", dtr_n, e_dtr);
            end
        end
        auto_rts = 0; auto_dtr = 0; tick(1);

        // R3 clear-to-send gating with character in flight
        auto_cts = 1; tick(4);
        check("R3 gate open", tx_allow, 1);
        data_req = 1; tick(1);
        check("R3 data start when open", start_data, 1);
        tx_busy = 1; tx_empty = 0; cts_n_pin = 1; tick(1);
        check("R3 no start while busy", start_data, 0);
        tick(4);
        check("R3 gate closed", tx_allow, 0);
        tx_busy = 0; tick(1);
        check("R3 no data after char ends", start_data, 0);
        flow_req = 1; #2;
        check("R5 flow bypasses closed gate", start_flow, 1);
        check("R5 data still held", start_data, 0);
        flow_req = 0; cts_n_pin = 0; tick(2);
        check("R3 still closed after two edges", tx_allow, 0);
        tick(1);
        check("R3 reopened on third edge", tx_allow, 1);
        check("R3 data resumes", start_data, 1);
        flow_req = 1; #2;
        check("R5 flow wins same cycle", start_flow, 1);
        check("R5 data yields same cycle", start_data, 0);
        tx_busy = 1; #2;
        check("R5 flow waits for idle", start_flow, 0);
        flow_req = 0; tx_busy = 0; data_req = 0; tx_empty = 1; auto_cts = 0; tick(1);

        // R4 data-set-ready gating
        auto_dsr = 1; tick(4);
        check("R4 gate closed on dsr", tx_allow, 0);
        dsr_n_pin = 0; tick(3);
        check("R4 gate reopened", tx_allow, 1);
        check("R4 dsr status", dsr_stat, 1);

        // R7 data-set-ready pin as receive clock
        dsr_n_pin = 1; rx_clk_src = 2'b01; tick(4);
        check("R7 repurposed pin not gating", tx_allow, 1);
        check("R7 ext clock high", ext_rx_clk, 1);
        dsr_n_pin = 0; tick(3);
        check("R7 status masked", dsr_stat, 0);
        check("R7 ext clock low", ext_rx_clk, 0);
        dsr_n_pin = 1; rx_clk_src = 2'b00; tick(1);
        check("R7 ext clock off", ext_rx_clk, 0);
        tick(2);
        check("R7 gating restored", tx_allow, 0);
        auto_dsr = 0; dsr_n_pin = 0;

        // R8 ring-indicator pin as transmit clock
        ri_n_pin = 0; tick(3);
        check("R8 ri status normal", ri_stat, 1);
        tx_clk_ext_sel = 1; #2;
        check("R8 ri status masked", ri_stat, 0);
        check("R8 ext tx clock low", ext_tx_clk, 0);
        ri_n_pin = 1; #2;
        check("R8 ext tx clock high", ext_tx_clk, 1);
        tx_clk_ext_sel = 0; #2;
        check("R8 ext tx clock off", ext_tx_clk, 0);

        // R6 RS485 direction
        tick(1);
        tx_empty = 0; dir_mode = 2'b01; tick(1);
        check("R6 mode01 low while sending", dtr_n, 0);
        tx_busy = 0; tick(1);
        check("R6 held through stop bit", dtr_n, 0);
        tx_empty = 1; tick(1);
        check("R6 mode01 released", dtr_n, 1);
        dir_mode = 2'b10; tick(1);
        check("R6 mode10 empty", dtr_n, 0);
        tx_empty = 0; tick(1);
        check("R6 mode10 sending", dtr_n, 1);
        dir_mode = 2'b11; tick(1);
        check("R6 mode11 as mode01", dtr_n, 0);
        dir_mode = 2'b01;

        // R9 transmit clock onto data-terminal-ready pin
        dtr_clk_route = 2'b01; tx_clk_1x = 1; tx_clk_nx = 0; #2;
        check("R9 1x high", dtr_n, 1);
        tx_clk_1x = 0; #2;
        check("R9 1x low", dtr_n, 0);
        dtr_clk_route = 2'b10; tx_clk_nx = 1; #2;
        check("R9 nx high", dtr_n, 1);
        dtr_clk_route = 2'b11; #2;
        check("R9 code 11 no clock", dtr_n, 0);
        dtr_clk_route = 2'b00;
        tick(2);
        finish_run();
    end
endmodule